// File: doc/BRIEF.md
# Transposing Stream Reorder Buffer

This block takes one frame of `ROWS x COLS` words from an AXI4-Stream slave port and stores it in an internal single-frame memory in arrival order. It then sends the frame out on an AXI4-Stream master port in transposed order, so consecutive output beats walk down a column of the stored frame. Once the whole frame has left, the block accepts the next frame.

The memory read path is two registers deep: a registered read address, then a registered data output. The output handshake never advances the read address. A read is issued only while the words already in the read path and the two-entry holding store, less the one leaving in the current cycle, number fewer than two. Because of this, a stall on the output at any cycle cannot lose, repeat or overwrite a word, and no separate stream FIFO sits after the memory. TVALID is raised in the same cycle a word reaches the memory data register or a holding register.

A three-state controller sequences the frame. `XS_FILL` accepts input beats. `XS_ISSUE` issues transposed read addresses whenever there is room. `XS_FLUSH` waits for the words still in flight to be sent. The transitions are:

- `XS_FILL` to `XS_ISSUE` when the last input beat of the frame is accepted.
- `XS_ISSUE` to `XS_FLUSH` when the last read address is issued.
- `XS_FLUSH` to `XS_FILL` when the last output beat is taken.

Top module: `xpose_stream_buf`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is held, and in the first cycle after it, `s_tready` is 1 and `m_tvalid` is 0.
- R2: `s_tready` is 1 from reset or frame end until exactly `ROWS*COLS` input beats have been accepted. It is then 0 until the last output beat of that frame is taken, and 1 again in the following cycle.
- R3: Input beats are numbered i = 0 .. ROWS*COLS-1 in acceptance order. Output beat k carries input beat (k mod ROWS)*COLS + (k div ROWS).
- R4: `s_tready` and `m_tvalid` are never 1 in the same cycle, and no read is issued while input is accepted.
- R5: While `m_tvalid` is 1 and `m_tready` is 0, the next cycle still has `m_tvalid` at 1 and the same `m_tdata`.
- R6: Each frame produces exactly ROWS*COLS output beats under any `m_tready` pattern. At most two words are held between the read address register and the output.
- R7: If the last input beat is accepted at clock edge n, `m_tvalid` is 0 before edge n+2 and 1 in the cycle after edge n+2.
- R8: Once `m_tvalid` has risen in a frame, it stays 1 in every cycle until that frame's last beat is taken, whatever the `m_tready` pattern.
- R9: A beat offered on `s_tvalid` while `s_tready` is 0 is not taken and leaves the frame being sent unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tdata | input | DATA_W | Input stream data |
| s_tvalid | input | 1 | Input stream valid |
| s_tready | output | 1 | Input stream ready |
| m_tdata | output | DATA_W | Output stream data |
| m_tvalid | output | 1 | Output stream valid |
| m_tready | input | 1 | Output stream ready |

## Verification
`s_tready` responds one edge after the last input or last output handshake. The first output word is due two edges after the edge that accepts the last input beat, and every later word is due in the cycle after the previous one is taken. The bench keeps a behavioural model built from queues and counters, which advances on the same handshakes. It samples the ports at the falling edge, so each comparison falls midway through the cycle in which the result is due. Data is compared only on actual handshakes. Valid and ready levels are compared on every cycle.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

    // Controller phases for one frame.
    typedef enum logic [1:0] {
        XS_FILL  = 2'd0,
        XS_ISSUE = 2'd1,
        XS_FLUSH = 2'd2
    } xs_state_e;

    // Words that may sit between the read address register and the output:
    // equal to the read latency in cycles.
    localparam int unsigned HOLD_CAP = 2;

endpackage

// File: rtl/xpose_wr_ctrl.sv
module xpose_wr_ctrl #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned AW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_fire,
    output logic [AW-1:0] wr_addr,
    output logic          wr_last
);

    logic [AW-1:0] cnt_q;

    assign wr_addr = cnt_q;
    assign wr_last = (cnt_q == AW'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_fire) begin
            cnt_q <= wr_last ? '0 : cnt_q + AW'(1);
        end
    end

endmodule

// File: rtl/xpose_rd_agen.sv
module xpose_rd_agen #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 4,
    parameter int unsigned AW   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] rd_addr,
    output logic          rd_last
);

    localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int unsigned CW = (COLS > 1) ? $clog2(COLS) : 1;

    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [AW-1:0] addr_q;
    logic          row_end;
    logic          col_end;

    assign row_end = (row_q == RW'(ROWS - 1));
    assign col_end = (col_q == CW'(COLS - 1));
    assign rd_last = row_end && col_end;
    assign rd_addr = addr_q;

    // Row index moves fastest; the address tracks row*COLS + col without a multiplier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            addr_q <= '0;
        end else if (step) begin
            if (rd_last) begin
                row_q  <= '0;
                col_q  <= '0;
                addr_q <= '0;
            end else if (row_end) begin
                row_q  <= '0;
                col_q  <= col_q + CW'(1);
                addr_q <= AW'(col_q) + AW'(1);
            end else begin
                row_q  <= row_q + RW'(1);
                addr_q <= addr_q + AW'(COLS);
            end
        end
    end

endmodule

// File: rtl/xpose_rd_pipe.sv
module xpose_rd_pipe #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic              st1_v,
    output logic              st2_v,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     addr_q;
    logic [DATA_W-1:0] dout_q;
    logic              v1_q;
    logic              v2_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Stage 1: registered read address.
    always_ff @(posedge clk) begin
        if (rd_en) begin
            addr_q <= rd_addr;
        end
    end

    // Stage 2: registered memory output.
    always_ff @(posedge clk) begin
        if (v1_q) begin
            dout_q <= mem[addr_q];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
        end else begin
            v1_q <= rd_en;
            v2_q <= v1_q;
        end
    end

    assign st1_v   = v1_q;
    assign st2_v   = v2_q;
    assign rd_data = dout_q;

endmodule

// File: rtl/xpose_hold.sv
module xpose_hold #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_v,
    input  logic [DATA_W-1:0] in_d,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic [1:0]        hcnt
);

    logic [DATA_W-1:0] ent_q [2];
    logic [DATA_W-1:0] ent_n [2];
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_n;
    logic              held;
    logic              push;
    logic              pop;

    assign held = (cnt_q != 2'd0);

    // The head holding register wins; otherwise the memory output register is shown directly.
    assign out_valid = held || in_v;
    assign out_data  = held ? ent_q[0] : in_d;

    // A pipeline word is parked when older words are held or the sink is stalled.
    assign push = in_v && (held || !out_ready);
    assign pop  = held && out_ready;

    always_comb begin
        ent_n[0] = ent_q[0];
        ent_n[1] = ent_q[1];
        cnt_n    = cnt_q;
        if (pop) begin
            ent_n[0] = ent_q[1];
            cnt_n    = cnt_q - 2'd1;
        end
        if (push) begin
            ent_n[cnt_n[0]] = in_d;
            cnt_n           = cnt_n + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        ent_q[0] <= ent_n[0];
        ent_q[1] <= ent_n[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
        end else begin
            cnt_q <= cnt_n;
        end
    end

    assign hcnt = cnt_q;

endmodule

// File: rtl/xpose_stream_buf.sv
module xpose_stream_buf
    import xpose_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ROWS   = 4,
    parameter int unsigned COLS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready
);

    localparam int unsigned DEPTH = ROWS * COLS;
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    xs_state_e         state_q;
    xs_state_e         state_d;
    logic              wr_fire;
    logic              wr_last;
    logic [AW-1:0]     wr_addr;
    logic              issue_en;
    logic [AW-1:0]     rd_addr;
    logic              rd_last;
    logic              st1_v;
    logic              st2_v;
    logic [DATA_W-1:0] rd_data;
    logic [1:0]        hcnt;
    logic [2:0]        occ_w;
    logic              room;
    logic              out_fire;
    logic [AW-1:0]     tx_q;
    logic              tx_last;

    assign wr_fire  = s_tvalid && s_tready;
    assign out_fire = m_tvalid && m_tready;
    assign tx_last  = out_fire && (tx_q == AW'(DEPTH - 1));

    // Words in flight plus words parked; the one leaving this cycle frees its slot.
    assign occ_w = 3'(st1_v) + 3'(st2_v) + 3'(hcnt);
    assign room  = (occ_w - 3'(out_fire)) < 3'(HOLD_CAP);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_FILL;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_FILL:  if (wr_fire && wr_last)  state_d = XS_ISSUE;
            XS_ISSUE: if (issue_en && rd_last) state_d = XS_FLUSH;
            XS_FLUSH: if (tx_last)             state_d = XS_FILL;
            default:                           state_d = XS_FILL;
        endcase
    end

    // Per-state outputs.
    always_comb begin
        s_tready = 1'b0;
        issue_en = 1'b0;
        unique case (state_q)
            XS_FILL:  s_tready = 1'b1;
            XS_ISSUE: issue_en = room;
            XS_FLUSH: ;
            default:  ;
        endcase
    end

    // Output beat counter, marks the end of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (out_fire) begin
            tx_q <= tx_last ? '0 : tx_q + AW'(1);
        end
    end

    xpose_wr_ctrl #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) wr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_last (wr_last)
    );

    xpose_rd_agen #(
        .ROWS (ROWS),
        .COLS (COLS),
        .AW   (AW)
    ) agen_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (issue_en),
        .rd_addr (rd_addr),
        .rd_last (rd_last)
    );

    xpose_rd_pipe #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .AW     (AW)
    ) pipe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (s_tdata),
        .rd_en   (issue_en),
        .rd_addr (rd_addr),
        .st1_v   (st1_v),
        .st2_v   (st2_v),
        .rd_data (rd_data)
    );

    xpose_hold #(
        .DATA_W (DATA_W)
    ) hold_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_v      (st2_v),
        .in_d      (rd_data),
        .out_ready (m_tready),
        .out_valid (m_tvalid),
        .out_data  (m_tdata),
        .hcnt      (hcnt)
    );

endmodule

// File: rtl/xpose_stream_buf_chk.sv
module xpose_stream_buf_chk
    import xpose_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              s_tready,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic [2:0]        occ,
    input logic              issue_en
);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R4
    phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_tready |-> !m_tvalid);

    // R4
    issue_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> !s_tready);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= 3'(HOLD_CAP));

    // R3
    data_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !$isunknown(m_tdata));

endmodule

bind xpose_stream_buf xpose_stream_buf_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_tready (s_tready),
    .m_tvalid (m_tvalid),
    .m_tready (m_tready),
    .m_tdata  (m_tdata),
    .occ      (occ_w),
    .issue_en (issue_en)
);

// File: tb/xpose_stream_buf_tb.sv
module xpose_stream_buf_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int ROWS       = 4;
    localparam int COLS       = 4;
    localparam int DEPTH      = ROWS * COLS;
    localparam int NFR        = 5;
    localparam int WDOG       = 20000;

    logic         clk;
    logic         rst_n;
    logic [W-1:0] s_tdata;
    logic         s_tvalid;
    logic         s_tready;
    logic [W-1:0] m_tdata;
    logic         m_tvalid;
    logic         m_tready;

    xpose_stream_buf #(.DATA_W(W), .ROWS(ROWS), .COLS(COLS)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_tdata  (s_tdata),
        .s_tvalid (s_tvalid),
        .s_tready (s_tready),
        .m_tdata  (m_tdata),
        .m_tvalid (m_tvalid),
        .m_tready (m_tready)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] word(input int i);
        return W'((i * 97) + ((i / DEPTH) * 1021) + 13);
    endfunction

    // Model state.
    logic [W-1:0] in_q[$];
    logic [W-1:0] out_q[$];
    bit           phase     = 0;
    int           wait_c    = 0;
    int           beats     = 0;
    int           in_total  = 0;
    int           out_frames = 0;
    int           offered   = 0;
    bit           frame_bad = 0;
    bit           acc_now   = 0;
    bit           prev_stall = 0;
    logic [W-1:0] prev_d    = '0;
    bit           run_model = 0;

    // Source and sink driver, a moment after each rising edge.
    int           src_idx = 0;
    int           rc      = 0;
    logic [15:0]  lf      = 16'hACE1;

    always begin
        @(posedge clk);
        #1;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        rc++;
        if (run_model) begin
            if (acc_now) src_idx++;
            if (src_idx / DEPTH >= NFR) begin
                s_tvalid = 1'b0;
            end else if (!s_tvalid || acc_now) begin
                s_tvalid = ((src_idx / DEPTH) == 1) ? lf[3] : 1'b1;
            end
            s_tdata = word(src_idx);
            case (out_frames)
                0:       m_tready = 1'b1;
                1:       m_tready = lf[0];
                2:       m_tready = ((rc % 10) >= 7);
                3:       m_tready = rc[0];
                default: m_tready = lf[1] & lf[2];
            endcase
        end
    end

    // Reference model, sampled at the falling edge.
    always @(negedge clk) begin
        if (run_model) begin
            bit           st;
            bit           mv;
            bit           mr;
            bit           exp_v;
            logic [W-1:0] md;
            logic [W-1:0] e;
            st = s_tready;
            mv = m_tvalid;
            mr = m_tready;
            md = m_tdata;

            // R2: ready only while filling
            chk(st == !phase, "R2", int'(st), int'(!phase));
            // R4: never both phases at once
            chk(!(st && mv), "R4", int'(st && mv), 0);

            if (phase) wait_c++;
            exp_v = phase && (wait_c >= 3);
            // R7 for the first beat, R8 afterwards
            chk(mv == exp_v, (beats == 0) ? "R7" : "R8", int'(mv), int'(exp_v));

            // R5: stalled word held
            if (prev_stall) chk(mv && (md == prev_d), "R5", int'(md), int'(prev_d));

            if (phase && s_tvalid && !st) offered++;

            if (mv && mr) begin
                if (out_q.size() == 0) begin
                    // R6: beat with nothing expected
                    chk(1'b0, "R6", 1, 0);
                end else begin
                    e = out_q.pop_front();
                    // R3: transposed order
                    chk(md == e, "R3", int'(md), int'(e));
                    if (md != e) frame_bad = 1;
                    beats++;
                    if (out_q.size() == 0) begin
                        // R6: exact beat count
                        chk(beats == DEPTH, "R6", beats, DEPTH);
                        // R9: offers during drain left the frame intact
                        if (offered > 0) chk(!frame_bad, "R9", int'(frame_bad), 0);
                        phase = 0;
                        beats = 0;
                        offered = 0;
                        frame_bad = 0;
                        out_frames++;
                    end
                end
            end

            acc_now = st && s_tvalid;
            if (acc_now) begin
                in_q.push_back(word(in_total));
                in_total++;
                if (in_q.size() == DEPTH) begin
                    for (int k = 0; k < DEPTH; k++) begin
                        out_q.push_back(in_q[(k % ROWS) * COLS + (k / ROWS)]);
                    end
                    in_q.delete();
                    phase = 1;
                    wait_c = 0;
                end
            end

            prev_stall = mv && !mr;
            prev_d     = md;
        end
    end

    initial begin
        int cyc;
        rst_n    = 1'b0;
        s_tvalid = 1'b0;
        s_tdata  = '0;
        m_tready = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(s_tready == 1'b1, "R1", int'(s_tready), 1);
        chk(m_tvalid == 1'b0, "R1", int'(m_tvalid), 0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after reset
        chk(s_tready == 1'b1 && m_tvalid == 1'b0, "R1", int'({s_tready, m_tvalid}), 2);
        run_model = 1;
        cyc = 0;
        while (out_frames < NFR && cyc < WDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (out_frames < NFR) chk(1'b0, "R6 watchdog", out_frames, NFR);
        repeat (4) @(posedge clk);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule